// File: doc/BRIEF.md
# Oversampling Serial Receiver with Edge Realignment

This block recovers 8-bit characters from an asynchronous serial line. A tick enable running at sixteen times the bit rate drives all sampling. While idle, the receiver watches for a qualified falling edge. Each bit is then judged by a two-of-three vote taken near the middle of the bit. A completed character is copied into a holding register, and a full flag is raised for the consumer.

The receiver tolerates a mismatch between the sender's bit rate and the local tick. It restarts its phase count at every start edge. Inside a frame, it also realigns to the falling edge whenever a data bit that voted high is followed by one that votes low. This keeps the vote window centred over long runs of alternating data. The consumer clears the full flag with a read pulse. An interrupt request follows the flag when enabled.

Top module: `serial_rx_resync`

## Requirements
- R1: A start bit is accepted only on a tick whose line sample is 0 when the three preceding tick samples were all 1; a low line not preceded by three high samples starts no frame.
- R2: The phase count is 1 on the tick that accepted the start edge and advances by one on each later tick, wrapping after 16; each bit value is the two-of-three majority of the samples at counts 8, 9 and 10, so one disturbed sample among them does not change the bit.
- R3: If the start bit's samples at counts 8, 9 and 10 vote 1, the frame is dropped: no character is stored and the search for a start edge resumes.
- R4: The start bit is followed by eight data bits, least significant first (the first data bit is bit 0 of the stored byte), then one stop bit; the stop bit is sampled but not stored, and the character is stored whatever the stop bit's value.
- R5: When a data bit voting 1 is followed by a data bit voting 0, the phase count is realigned so that the last observed 1-to-0 line transition becomes count 1; each bit is voted exactly once, so frames sent at 14 or 18 ticks per bit with alternating data are recovered correctly.
- R6: Storing a character sets `rx_full` and loads `rx_data`; `rx_data` changes at no other time.
- R7: `rx_irq` is high exactly when `rx_full` and `irq_en` are both high.
- R8: A one-cycle `rd_strobe` clears `rx_full`, and therefore `rx_irq`, at the next clock edge; a store in the same cycle takes priority and leaves the flag set.
- R9: The search for the next start edge begins right after the stop bit's count-10 sample, so frames sent with no idle time between them are all received.
- R10: After reset, `rx_full`, `rx_irq` and `rx_data` are 0 and the receiver is searching for a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample enable, sixteen per bit time |
| rx_in | input | 1 | Serial receive line, idle high |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle pulse that clears the full flag |
| rx_data | output | 8 | Last stored character |
| rx_full | output | 1 | A stored character is waiting |
| rx_irq | output | 1 | Interrupt request |

## Verification
Every byte value is sent as frames back to back with no idle time. A receiver that reopened its search late would lose or shift the next frame, and one with the wrong bit order would store mirrored data. Frames stretched to 18 ticks per bit and squeezed to 14 ticks per bit carry patterns rich in 1-to-0 transitions. A receiver without realignment drifts into the neighbouring bit. A receiver that realigned but allowed a second vote in the same bit would shift in a duplicate bit. Single disturbed samples at counts 9 and 10 check the vote. So do a low pulse too short to be a start, and a low line right after reset without three prior high samples; a receiver that trusted a single low sample would store a character from either. A stop bit held low checks that storing does not depend on the stop value.

// File: rtl/rxos_pkg.sv
package rxos_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/rxos_sync.sv
module rxos_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES:0] chain;

   assign chain[0] = din;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= IDLE;
         else        chain[i+1] <= chain[i];
      end
   end

   assign dout = chain[STAGES];

endmodule

// File: rtl/rxos_sampler.sv
module rxos_sampler
   import rxos_pkg::*;
#(
   parameter int OS_RATE = 16,
   localparam int PH_W   = $clog2(OS_RATE),
   localparam int MID    = OS_RATE / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            os_tick,
   input  logic            din,
   input  logic            hunting,
   input  logic            decide,
   input  logic [PH_W-1:0] cnt_now,
   output logic            start_hit,
   output logic            vote,
   output logic            edge_now,
   output logic [PH_W-1:0] since_now
);

   localparam logic [PH_W-1:0] SMP_A     = PH_W'(MID);
   localparam logic [PH_W-1:0] SMP_B     = PH_W'(MID + 1);
   localparam logic [PH_W-1:0] SINCE_MAX = '1;

   logic [2:0]      hist_q;
   logic            s_a_q;
   logic            s_b_q;
   logic [PH_W-1:0] since_q;
   logic            eflag_q;
   logic            falling;

   always_comb begin
      falling   = os_tick && hist_q[0] && !din;
      start_hit = os_tick && hunting && !din && (hist_q == 3'b111);
      vote      = vote3(s_a_q, s_b_q, din);
      edge_now  = eflag_q || falling;
      if (falling)                  since_now = PH_W'(1);
      else if (since_q == SINCE_MAX) since_now = SINCE_MAX;
      else                           since_now = since_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= 3'b000;
         s_a_q   <= 1'b1;
         s_b_q   <= 1'b1;
         since_q <= SINCE_MAX;
         eflag_q <= 1'b0;
      end else if (os_tick) begin
         hist_q  <= {hist_q[1:0], din};
         since_q <= since_now;
         eflag_q <= decide ? 1'b0 : (eflag_q || falling);
         if (cnt_now == SMP_A) s_a_q <= din;
         if (cnt_now == SMP_B) s_b_q <= din;
      end
   end

endmodule

// File: rtl/rxos_seq.sv
module rxos_seq
   import rxos_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OS_RATE   = 16,
   localparam int PH_W     = $clog2(OS_RATE),
   localparam int BC_W     = $clog2(DATA_BITS),
   localparam int MID      = OS_RATE / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  logic                 start_hit,
   input  logic                 vote,
   input  logic                 edge_now,
   input  logic [PH_W-1:0]      since_now,
   output logic [PH_W-1:0]      cnt_now,
   output logic [PH_W-1:0]      phase,
   output logic                 hunting,
   output logic                 decide,
   output logic                 load,
   output logic [DATA_BITS-1:0] word,
   output rx_state_e            state
);

   localparam logic [PH_W-1:0] SMP_C    = PH_W'(MID + 2);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_BITS - 1);

   rx_state_e            state_q;
   logic [PH_W-1:0]      phase_q;
   logic [BC_W-1:0]      bcnt_q;
   logic [DATA_BITS-1:0] shreg_q;
   logic                 last_q;
   logic                 armed_q;
   logic                 load_q;

   always_comb begin
      cnt_now = phase_q + 1'b1;
      hunting = (state_q == ST_HUNT);
      decide  = os_tick && !hunting && armed_q && (cnt_now == SMP_C);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         phase_q <= '0;
         bcnt_q  <= '0;
         shreg_q <= '0;
         last_q  <= 1'b0;
         armed_q <= 1'b0;
         load_q  <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (hunting) begin
            if (start_hit) begin
               state_q <= ST_START;
               phase_q <= PH_W'(1);
               armed_q <= 1'b1;
            end
         end else if (os_tick) begin
            phase_q <= cnt_now;
            if (cnt_now == '0) armed_q <= 1'b1;
            if (decide) begin
               armed_q <= 1'b0;
               case (state_q)
                  ST_START: begin
                     if (vote) begin
                        state_q <= ST_HUNT;
                     end else begin
                        state_q <= ST_DATA;
                        bcnt_q  <= '0;
                        last_q  <= 1'b0;
                     end
                  end
                  ST_DATA: begin
                     shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
                     last_q  <= vote;
                     if (last_q && !vote && edge_now) phase_q <= since_now;
                     if (bcnt_q == LAST_BIT) state_q <= ST_STOP;
                     else                    bcnt_q  <= bcnt_q + 1'b1;
                  end
                  ST_STOP: begin
                     load_q  <= 1'b1;
                     state_q <= ST_HUNT;
                  end
                  default: state_q <= ST_HUNT;
               endcase
            end
         end
      end
   end

   assign phase = phase_q;
   assign load  = load_q;
   assign word  = shreg_q;
   assign state = state_q;

endmodule

// File: rtl/rxos_buf.sv
module rxos_buf #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] din,
   input  logic                 rd,
   output logic [DATA_BITS-1:0] dout,
   output logic                 full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
      end else begin
         if (load) begin
            dout <= din;
            full <= 1'b1;
         end else if (rd) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/serial_rx_resync.sv
module serial_rx_resync
   import rxos_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2,
   localparam int PH_W       = $clog2(OS_RATE)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  logic                 rx_in,
   input  logic                 irq_en,
   input  logic                 rd_strobe,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_full,
   output logic                 rx_irq
);

   initial begin
      assert (OS_RATE >= 8 && (OS_RATE & (OS_RATE - 1)) == 0)
         else $error("OS_RATE must be a power of two of at least 8");
      assert (DATA_BITS >= 2)
         else $error("DATA_BITS must be at least 2");
      assert (SYNC_STAGES >= 0)
         else $error("SYNC_STAGES must not be negative");
   end

   logic                 sync_rx;
   logic                 smp_start;
   logic                 smp_vote;
   logic                 smp_edge;
   logic [PH_W-1:0]      smp_since;
   logic [PH_W-1:0]      seq_cnt;
   logic [PH_W-1:0]      seq_phase;
   logic                 seq_hunt;
   logic                 seq_decide;
   logic                 seq_load;
   logic [DATA_BITS-1:0] seq_word;
   rx_state_e            seq_state;

   rxos_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_in),
      .dout (sync_rx)
   );

   rxos_sampler #(.OS_RATE(OS_RATE)) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .din      (sync_rx),
      .hunting  (seq_hunt),
      .decide   (seq_decide),
      .cnt_now  (seq_cnt),
      .start_hit(smp_start),
      .vote     (smp_vote),
      .edge_now (smp_edge),
      .since_now(smp_since)
   );

   rxos_seq #(.DATA_BITS(DATA_BITS), .OS_RATE(OS_RATE)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .start_hit(smp_start),
      .vote     (smp_vote),
      .edge_now (smp_edge),
      .since_now(smp_since),
      .cnt_now  (seq_cnt),
      .phase    (seq_phase),
      .hunting  (seq_hunt),
      .decide   (seq_decide),
      .load     (seq_load),
      .word     (seq_word),
      .state    (seq_state)
   );

   rxos_buf #(.DATA_BITS(DATA_BITS)) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .load (seq_load),
      .din  (seq_word),
      .rd   (rd_strobe),
      .dout (rx_data),
      .full (rx_full)
   );

   assign rx_irq = rx_full & irq_en;

endmodule

// File: rtl/serial_rx_resync_chk.sv
module serial_rx_resync_chk
   import rxos_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int PH_W      = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 os_tick,
   input logic                 irq_en,
   input logic                 rd_strobe,
   input logic                 rx_full,
   input logic                 rx_irq,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 load,
   input rx_state_e            state,
   input logic [PH_W-1:0]      phase
);

   assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq == (rx_full && irq_en));

   assert_load_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rx_full);

   assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(rx_data));

   assert_full_rises_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(load));

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !load) |=> !rx_full);

   assert_hunt_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && !os_tick) |=> state == ST_HUNT);

   assert_phase_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !os_tick |=> $stable(phase));

endmodule

bind serial_rx_resync serial_rx_resync_chk #(.DATA_BITS(DATA_BITS), .PH_W(PH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .os_tick  (os_tick),
   .irq_en   (irq_en),
   .rd_strobe(rd_strobe),
   .rx_full  (rx_full),
   .rx_irq   (rx_irq),
   .rx_data  (rx_data),
   .load     (seq_load),
   .state    (seq_state),
   .phase    (seq_phase)
);

// File: tb/tb_serial_rx_resync.sv
module tb_serial_rx_resync;

   localparam int WD_LIMIT = 195000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       irq_en = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full;
   logic       rx_irq;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serial_rx_resync dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .rx_in    (rx_in),
      .irq_en   (irq_en),
      .rd_strobe(rd_strobe),
      .rx_data  (rx_data),
      .rx_full  (rx_full),
      .rx_irq   (rx_irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish act=%0d exp<=%0d", cyc, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // one oversample tick carrying line value v; starts and ends at a negedge
   task automatic tick1(input logic v);
      rx_in = v;
      @(negedge clk);
      @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick1(1'b1);
   endtask

   // gb: bit index in frame (0 start, 1..8 data, 9 stop); gt: tick index in bit
   task automatic send_frame(input logic [7:0] d, input logic stopv, input int per,
                             input int gb, input int gt);
      logic [9:0] bits;
      bits = {stopv, d, 1'b0};
      for (int b = 0; b < 10; b++) begin
         for (int t = 0; t < per; t++) begin
            if (b == gb && t == gt) tick1(~bits[b]);
            else                    tick1(bits[b]);
         end
      end
   endtask

   task automatic read_clear();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic expect_byte(input string req, input logic [7:0] d);
      chk({req, " full"}, {31'd0, rx_full}, 32'd1);
      chk({req, " data"}, {24'd0, rx_data}, {24'd0, d});
      read_clear();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      irq_en = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 full", {31'd0, rx_full}, 32'd0);
      chk("R10 irq", {31'd0, rx_irq}, 32'd0);
      chk("R10 data", {24'd0, rx_data}, 32'd0);

      // R1: only two high samples before a long low run: no start accepted
      idle(2);
      for (int i = 0; i < 144; i++) tick1(1'b0);
      idle(20);
      chk("R1 no start without three highs", {31'd0, rx_full}, 32'd0);

      // R4 R6 R7 basic frame with interrupt enabled
      send_frame(8'hA5, 1'b1, 16, -1, 0);
      idle(4);
      chk("R6 full after frame", {31'd0, rx_full}, 32'd1);
      chk("R4 lsb-first data", {24'd0, rx_data}, 32'h0A5);
      chk("R7 irq with enable", {31'd0, rx_irq}, 32'd1);
      read_clear();
      chk("R8 full cleared by read", {31'd0, rx_full}, 32'd0);
      chk("R8 irq cleared by read", {31'd0, rx_irq}, 32'd0);

      // R3 false start: 4 low samples, vote at 8/9/10 is high
      for (int i = 0; i < 4; i++) tick1(1'b0);
      idle(20);
      chk("R3 false start stores nothing", {31'd0, rx_full}, 32'd0);
      chk("R6 data unchanged without store", {24'd0, rx_data}, 32'h0A5);
      send_frame(8'h3C, 1'b1, 16, -1, 0);
      idle(4);
      chk("R3 search resumes after false start", {24'd0, rx_data}, 32'h03C);

      // R7 enable low
      irq_en = 1'b0;
      @(negedge clk);
      chk("R7 full while enable low", {31'd0, rx_full}, 32'd1);
      chk("R7 irq masked", {31'd0, rx_irq}, 32'd0);
      read_clear();
      irq_en = 1'b1;

      // R2 single disturbed samples
      send_frame(8'hA5, 1'b1, 16, 3, 8);
      idle(4);
      expect_byte("R2 glitch count9 high bit", 8'hA5);
      send_frame(8'hA5, 1'b1, 16, 4, 9);
      idle(4);
      expect_byte("R2 glitch count10 low bit", 8'hA5);
      send_frame(8'h96, 1'b1, 16, 0, 8);
      idle(4);
      expect_byte("R2 glitch in start bit", 8'h96);

      // R4 stop bit low still stores
      send_frame(8'h81, 1'b0, 16, -1, 0);
      idle(20);
      expect_byte("R4 stop low stored", 8'h81);

      // R5 rate mismatch
      send_frame(8'h55, 1'b1, 14, -1, 0);
      idle(6);
      expect_byte("R5 fast sender 55", 8'h55);
      send_frame(8'h55, 1'b1, 18, -1, 0);
      idle(6);
      expect_byte("R5 slow sender 55", 8'h55);
      send_frame(8'h33, 1'b1, 18, -1, 0);
      idle(6);
      expect_byte("R5 slow sender 33", 8'h33);

      // R9 all byte values back to back, no idle ticks between frames
      for (int v = 0; v < 256; v++) begin
         send_frame(8'(v), 1'b1, 16, -1, 0);
         chk("R9 back-to-back full", {31'd0, rx_full}, 32'd1);
         chk("R9 back-to-back data", {24'd0, rx_data}, v);
         read_clear();
      end

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule